// File: doc/BRIEF.md
# Chained Serial Converter Readout Controller

This controller runs the host side of a string of serial sampling converters wired as a daisy chain. Each device's data output feeds the data input of the next one, and only the output of the device nearest the host comes back to the controller. A start request raises the shared convert line while the serial clock rests high. This puts every device into the chained mode with a completion flag. The convert line then stays high for the whole transaction.

The controller does not wait a fixed time. It watches the returning data line for a low-to-high step, which means every device in the chain has finished converting. It then issues one serial clock more than the total number of result bits. The chain shifts like one long register, so the controller collects all results MSB first, one device after another, on rising clock edges. The results are presented as one word per device with a one-cycle strobe.

If the completion step never arrives, the controller gives up after a programmable wait, drops the convert line and flags a timeout. A minimum spacing between accepted starts guarantees the converters their acquisition time. Clock divider, chain length, word size, timeout and minimum cycle are parameters.

Top module: `chain_adc_host`

## Requirements
- R1: After reset, cnv_o is low, sck_o is high, and valid_o and timeout_o are low.
- R2: A start request accepted while idle raises cnv_o with sck_o high. sck_o stays high until the completion step is seen on sdo_i.
- R3: cnv_o stays high from the accepted start through the last serial clock. Every falling edge of sck_o occurs while cnv_o is high, and sck_o stays high whenever cnv_o is low.
- R4: No falling edge of sck_o occurs before sdo_i has gone from low to high while cnv_o is high.
- R5: One readback produces exactly BITS*N_DEV+1 falling edges of sck_o. Each sck_o phase lasts SCK_DIV clock cycles.
- R6: The bit on sdo_i just before each of the first BITS*N_DEV rising edges of sck_o is collected, MSB first. The first BITS bits form word 0 (the device nearest the host), placed at words_o[BITS-1:0]. Word k sits at words_o[k*BITS +: BITS].
- R7: When the last serial clock completes, valid_o pulses high for exactly one cycle and cnv_o drops in that same cycle. words_o then holds its value until the next readback starts.
- R8: If sdo_i shows no rising step within TIMEOUT_CYC cycles of an accepted start, cnv_o drops and timeout_o pulses for one cycle. No serial clock is issued and valid_o stays low.
- R9: A start request that comes fewer than MIN_CYCLE cycles after the previous accepted start is ignored, and so is a start request during a transaction. In either case cnv_o stays low or unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request for a new conversion and readback |
| cnv_o | output | 1 | Shared convert line for the chain |
| sck_o | output | 1 | Serial clock for the chain, idles high |
| sdo_i | input | 1 | Data and completion line from the device nearest the host |
| words_o | output | N_DEV*BITS | Collected results, word 0 in the low bits |
| valid_o | output | 1 | One-cycle strobe when all words are complete |
| timeout_o | output | 1 | One-cycle strobe when the completion step did not arrive |

## Verification
The chain is modelled by one behavioural converter per position, each with a different conversion time, so the completion step is set by the slowest device. Results are tried with distinct per-device values, alternating-bit values and an all-ones/all-zeros mix. These show a bit-order error, an off-by-one against the busy position, and a swap of word order between devices. A held-low completion line exercises the timeout path. Start pulses placed right after a result check that the minimum cycle spacing is enforced.

// File: rtl/chain_adc_host.sv
module chain_adc_host #(
  parameter int N_DEV       = 3,
  parameter int BITS        = 18,
  parameter int SCK_DIV     = 2,
  parameter int TIMEOUT_CYC = 200,
  parameter int MIN_CYCLE   = 400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  output logic                  cnv_o,
  output logic                  sck_o,
  input  logic                  sdo_i,
  output logic [N_DEV*BITS-1:0] words_o,
  output logic                  valid_o,
  output logic                  timeout_o
);
  localparam int WW    = N_DEV * BITS;
  localparam int TOTAL = WW + 1;
  localparam int TW    = $clog2(TIMEOUT_CYC + 1);
  localparam int PW    = $clog2(MIN_CYCLE + 1);
  localparam int DW    = $clog2(SCK_DIV + 1);
  localparam int BW    = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_READ} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [PW-1:0] since;
  logic [DW-1:0] div;
  logic [BW-1:0] clks;
  logic [WW-1:0] shreg;
  logic          sdo_q;

  wire since_ok = (since == PW'(MIN_CYCLE - 1));
  wire accept   = (st == S_IDLE) && start_i && since_ok;
  wire busy_end = sdo_i && !sdo_q;
  wire tick     = (div == DW'(SCK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnv_o     <= 1'b0;
      sck_o     <= 1'b1;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      tmr       <= '0;
      since     <= PW'(MIN_CYCLE - 1);
      div       <= '0;
      clks      <= '0;
      shreg     <= '0;
      sdo_q     <= 1'b0;
    end else begin
      sdo_q     <= sdo_i;
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      if (!since_ok) since <= since + 1'b1;
      unique case (st)
        S_IDLE: begin
          sck_o <= 1'b1;
          if (accept) begin
            st    <= S_WAIT;
            cnv_o <= 1'b1;
            tmr   <= '0;
            since <= '0;
          end
        end
        S_WAIT: begin
          if (busy_end) begin
            st   <= S_READ;
            div  <= '0;
            clks <= '0;
          end else if (tmr == TW'(TIMEOUT_CYC - 1)) begin
            st        <= S_IDLE;
            cnv_o     <= 1'b0;
            timeout_o <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_READ: begin
          if (!tick) begin
            div <= div + 1'b1;
          end else begin
            div   <= '0;
            sck_o <= ~sck_o;
            if (!sck_o) begin
              if (clks < BW'(TOTAL - 1)) shreg <= {shreg[WW-2:0], sdo_i};
              clks <= clks + 1'b1;
              if (clks == BW'(TOTAL - 1)) begin
                st      <= S_IDLE;
                cnv_o   <= 1'b0;
                valid_o <= 1'b1;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < N_DEV; k++) begin : g_word
    assign words_o[k*BITS +: BITS] = shreg[(N_DEV-1-k)*BITS +: BITS];
  end

  a_r2_cnv_rise_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> sck_o);
  a_r2_wait_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> sck_o);
  a_r3_fall_under_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sck_o) |-> cnv_o);
  a_r3_idle_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_o |-> sck_o);
  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r7_valid_ends_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !cnv_o);
  a_r8_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!valid_o && !cnv_o && sck_o));
endmodule

// File: tb/chain_adc_host_tb.sv
module conv_chain_model #(
  parameter int BITS     = 18,
  parameter int CONV_CYC = 30
) (
  input  logic            clk,
  input  logic            cnv,
  input  logic            sck,
  input  logic            sdi,
  input  logic            hang,
  input  logic [BITS-1:0] sample,
  output logic            sdo
);
  logic            cnv_q = 1'b0, sck_q = 1'b1, busy_ph = 1'b0, done = 1'b0;
  logic [BITS-1:0] sr = '0;
  int              cnt = 0;

  assign sdo = cnv_q & (busy_ph ? (done & sdi) : sr[BITS-1]);

  always @(posedge clk) begin
    cnv_q <= cnv;
    sck_q <= sck;
    if (cnv && !cnv_q && sck) begin
      busy_ph <= 1'b1;
      done    <= 1'b0;
      sr      <= sample;
      cnt     <= 0;
    end else if (cnv) begin
      if (busy_ph && !done && !hang) begin
        cnt <= cnt + 1;
        if (cnt == CONV_CYC) done <= 1'b1;
      end
      if (sck_q && !sck) begin
        if (busy_ph) busy_ph <= 1'b0;
        else         sr <= {sr[BITS-2:0], sdi};
      end
    end
  end
endmodule

module chain_adc_host_tb;
  localparam int N_DEV = 3, BITS = 18, SCK_DIV = 2, TIMEOUT_CYC = 200, MIN_CYCLE = 400;
  localparam int WW = N_DEV * BITS;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, hang = 1'b0;
  logic cnv_o, sck_o, sdo_i, valid_o, timeout_o;
  logic [WW-1:0] words_o;
  logic [BITS-1:0] samp [N_DEV];
  logic [N_DEV:0] chain;

  int checks = 0, fails = 0;
  int falls = 0, bad_falls = 0, early_falls = 0, cnv_rises = 0, valids = 0, touts = 0;
  logic sck_at_rise = 1'b0, busy_seen = 1'b0;
  logic [BITS-1:0] exp_q [$];

  always #2 clk = ~clk;

  chain_adc_host #(.N_DEV(N_DEV), .BITS(BITS), .SCK_DIV(SCK_DIV),
                   .TIMEOUT_CYC(TIMEOUT_CYC), .MIN_CYCLE(MIN_CYCLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cnv_o(cnv_o), .sck_o(sck_o),
    .sdo_i(sdo_i), .words_o(words_o), .valid_o(valid_o), .timeout_o(timeout_o));

  assign chain[N_DEV] = cnv_o;
  assign sdo_i = chain[0];
  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    conv_chain_model #(.BITS(BITS), .CONV_CYC(30 + 7*k)) u_dev (
      .clk(clk), .cnv(cnv_o), .sck(sck_o), .sdi(chain[k+1]), .hang(hang),
      .sample(samp[k]), .sdo(chain[k]));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(negedge sck_o) begin
    falls++;
    if (!cnv_o) bad_falls++;
    if (!busy_seen) early_falls++;
  end
  always @(posedge cnv_o) begin
    cnv_rises++;
    sck_at_rise = sck_o;
  end
  always @(posedge clk) begin
    if (start_i) busy_seen <= 1'b0;
    else if (cnv_o && sdo_i) busy_seen <= 1'b1;
  end

  // scoreboard monitor: R6, R7
  always @(negedge clk) begin
    if (rst_n && timeout_o) touts++;
    if (rst_n && valid_o) begin
      valids++;
      chk(!cnv_o, "R7", "cnv low with valid", cnv_o, 0);
      for (int k = 0; k < N_DEV; k++) begin
        if (exp_q.size() == 0) chk(0, "R6", "unexpected word", k, 0);
        else begin
          automatic logic [BITS-1:0] e = exp_q.pop_front();
          chk(words_o[k*BITS +: BITS] == e, "R6", $sformatf("word %0d", k),
              words_o[k*BITS +: BITS], e);
        end
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_conv(input logic [BITS-1:0] s0, input logic [BITS-1:0] s1,
                          input logic [BITS-1:0] s2);
    int f0, v0, r0;
    logic [WW-1:0] snap;
    samp[0] = s0; samp[1] = s1; samp[2] = s2;
    exp_q.push_back(s0); exp_q.push_back(s1); exp_q.push_back(s2);
    f0 = falls; v0 = valids; r0 = cnv_rises;
    pulse_start();
    chk(cnv_rises == r0 + 1, "R2", "cnv raised", cnv_rises - r0, 1);
    chk(sck_at_rise, "R2", "sck at cnv rise", sck_at_rise, 1);
    @(negedge clk iff (valid_o || timeout_o));
    @(negedge clk);
    chk(valids == v0 + 1, "R7", "valid pulses", valids - v0, 1);
    chk(!valid_o, "R7", "valid width", valid_o, 0);
    chk(falls - f0 == WW + 1, "R5", "sck falls", falls - f0, WW + 1);
    chk(early_falls == 0, "R4", "falls before busy", early_falls, 0);
    chk(bad_falls == 0, "R3", "falls without cnv", bad_falls, 0);
    snap = words_o;
    repeat (20) @(negedge clk);
    chk(words_o == snap, "R7", "words held", words_o, snap);
    chk(sck_o && !cnv_o, "R3", "idle lines", {cnv_o, sck_o}, 2'b01);
    r0 = cnv_rises;
    pulse_start();
    repeat (4) @(negedge clk);
    chk(cnv_rises == r0 && !cnv_o, "R9", "early start ignored", cnv_rises - r0, 0);
    repeat (MIN_CYCLE) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R7", "watchdog valid", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    samp[0] = '0; samp[1] = '0; samp[2] = '0;
    repeat (3) @(negedge clk);
    chk(!cnv_o, "R1", "reset cnv", cnv_o, 0);
    chk(sck_o, "R1", "reset sck", sck_o, 1);
    chk(!valid_o && !timeout_o, "R1", "reset strobes", {valid_o, timeout_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_conv(18'h2C3A1, 18'h0F00D, 18'h3B7E5);
    run_conv(18'h2AAAA, 18'h15555, 18'h2AAAA);
    run_conv(18'h3FFFF, 18'h00000, 18'h20001);

    begin : timeout_case
      int f0, v0, t0, c;
      hang = 1'b1;
      f0 = falls; v0 = valids; t0 = touts; c = 0;
      pulse_start();
      while (!timeout_o && c < 3*TIMEOUT_CYC) begin
        @(negedge clk);
        c++;
      end
      @(negedge clk);
      chk(touts == t0 + 1, "R8", "timeout pulse", touts - t0, 1);
      chk(!cnv_o, "R8", "cnv dropped", cnv_o, 0);
      chk(falls == f0 && valids == v0, "R8", "no clocks or valid", falls - f0, 0);
      hang = 1'b0;
      repeat (MIN_CYCLE) @(posedge clk);
    end

    run_conv(18'h00001, 18'h20000, 18'h1E0F3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule